// File: doc/BRIEF.md
# Sliding Row Cache Buffer

This block keeps a short window of consecutive image rows on chip, so that a coordinate-conversion pipeline can fetch single pixels with a fixed one-cycle response. It works like a ring of row slots. The buffer asks external memory for rows in ascending order through a request stream. Whole rows then come back as 128-bit beats on a fill stream. The consumer reads by row and column. For every read, one cycle later, the buffer reports either valid data or a miss, and the consumer uses the miss to stall.

The window only ever moves forward. When the consumer pulses `row_done`, the lowest resident row is retired and its slot is freed. The freed slot is requested again at once for the next row beyond the window, so the row is already on its way before the pipeline needs it. Row `r` always lives in slot `r mod NUM_SLOTS`. The slot count must therefore be a power of two and at least 2.

Stream rules:
- The request stream holds `req_valid` and a stable `req_row` until `req_ready` is seen high on a clock edge.
- The fill stream is never back-pressured, so `fill_ready` is constantly high.
- Reads carry no ready signal. A read whose data is not resident returns a miss, and the consumer retries it.

Top module: `sliding_row_cache`

## Requirements
- R1: After reset no row is resident. `req_valid` is 1, `req_row` is 0, and `rd_data_valid` and `rd_miss` are both 0.
- R2: Row requests start at row 0 and rise by one for each accepted handshake (`req_valid` and `req_ready` high on an edge). While a request waits for `req_ready`, `req_valid` stays high and `req_row` is unchanged. `req_valid` is low whenever NUM_SLOTS requested rows are still resident, or whenever NUM_ROWS rows have been requested.
- R3: A fill beat at index `b` (0 to 7) of row `r` carries pixels `8b` to `8b+7`. Pixel `8b+k` sits in bits `[16k+15:16k]`. `fill_ready` is always 1. A fill for a row that is not resident in that cycle is dropped, and a later read of that beat still misses.
- R4: A read hits when its row is resident and the beat holding its column was filled on an earlier edge. On the following cycle `rd_data_valid` is 1 for one cycle, `rd_miss` is 0, and `rd_data` is the pixel.
- R5: Any other read gives `rd_miss` = 1 and `rd_data_valid` = 0 on the following cycle. This includes a read made in the same cycle as the fill of its beat. A cycle without a read gives both flags 0 on the next cycle.
- R6: A `row_done` pulse retires the lowest resident row. Reads of that row in later cycles miss, and the freed slot is requested for the next row. A read in the same cycle as the pulse still hits. A pulse when no row is resident is ignored.
- R7: The first read after reset misses.
- R8: When a slot is reused for a new row, none of the old row's beats are visible. Every beat of the new row misses until that beat is filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | output | 1 | Row fetch request pending |
| req_ready | input | 1 | Memory side accepts the request |
| req_row | output | ROW_W | Row being requested |
| fill_valid | input | 1 | Fill beat present |
| fill_ready | output | 1 | Always 1 |
| fill_row | input | ROW_W | Row of the fill beat |
| fill_beat | input | log2(beats per row) | Beat index within the row |
| fill_data | input | BEAT_W | Eight packed pixels |
| row_done | input | 1 | Retire the lowest resident row |
| rd_valid | input | 1 | Read request |
| rd_row | input | ROW_W | Read row |
| rd_col | input | log2(ROW_PIX) | Read column |
| rd_data | output | PIX_W | Pixel returned on a hit |
| rd_data_valid | output | 1 | Hit response, one cycle after the read |
| rd_miss | output | 1 | Miss response, one cycle after the read |

## Verification
A directed opening covers several distinct cases:
- a read, and a `row_done` pulse, issued before anything is resident;
- requests held off by a low `req_ready`, and a window that has filled up;
- a fill and a read of the same beat in the same cycle;
- a fill dropped because its row was not yet allocated;
- a retire that falls in the same cycle as a read, and a slot reused for a new row.

Together these separate a same-cycle fill hit from a registered one, and an early retire from a correct one. They also separate a stale slot from a cleared one. A seeded random phase then mixes back-pressure, fills of rows inside and just outside the window, reads around both window edges, and random retires. It runs until all rows have been requested and retired, which also exercises the end-of-image stop on requests.

// File: rtl/srcb_pkg.sv
package srcb_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_HIT  = 2'd1,
    RSP_MISS = 2'd2
  } rsp_kind_t;
endpackage

// File: rtl/srcb_window_ctrl.sv
// Window bookkeeping: the base and next row counters, the fetch request
// stream, and the per-slot valid bit and row tag.
module srcb_window_ctrl #(
  parameter int NUM_SLOTS = 4,
  parameter int ROW_W     = 8,
  parameter int NUM_ROWS  = 64,
  parameter int SLOT_W    = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_ready,
  input  logic                            row_done,
  output logic                            req_valid,
  output logic [ROW_W-1:0]                req_row,
  output logic                            alloc_fire,
  output logic [SLOT_W-1:0]               alloc_slot,
  output logic [NUM_SLOTS-1:0]            slot_valid,
  output logic [NUM_SLOTS-1:0][ROW_W-1:0] slot_tag
);
  localparam int CNT_W = ROW_W + 1;
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(NUM_SLOTS);
  localparam logic [CNT_W-1:0] ROWS_C  = CNT_W'(NUM_ROWS);

  logic [CNT_W-1:0]  base_row;
  logic [CNT_W-1:0]  next_row;
  logic [CNT_W-1:0]  occupancy;
  logic              retire;
  logic [SLOT_W-1:0] base_slot;

  always_comb begin
    occupancy  = next_row - base_row;
    req_valid  = (occupancy < SLOTS_C) && (next_row < ROWS_C);
    req_row    = next_row[ROW_W-1:0];
    alloc_fire = req_valid && req_ready;
    alloc_slot = next_row[SLOT_W-1:0];
    retire     = row_done && (occupancy != '0);
    base_slot  = base_row[SLOT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_row <= '0;
      next_row <= '0;
    end else begin
      if (alloc_fire) next_row <= next_row + 1'b1;
      if (retire)     base_row <= base_row + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_valid[i] <= 1'b0;
        slot_tag[i]   <= '0;
      end else if (alloc_fire && (alloc_slot == SLOT_W'(i))) begin
        slot_valid[i] <= 1'b1;
        slot_tag[i]   <= next_row[ROW_W-1:0];
      end else if (retire && (base_slot == SLOT_W'(i))) begin
        slot_valid[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srcb_slot_store.sv
// Row data storage, one beat per entry, plus a written-beat mask per slot.
module srcb_slot_store #(
  parameter int NUM_SLOTS = 4,
  parameter int BEATS     = 8,
  parameter int BEAT_W    = 128,
  parameter int SLOT_W    = 2,
  parameter int BIDX_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            alloc_fire,
  input  logic [SLOT_W-1:0]               alloc_slot,
  input  logic                            wr_en,
  input  logic [SLOT_W-1:0]               wr_slot,
  input  logic [BIDX_W-1:0]               wr_beat,
  input  logic [BEAT_W-1:0]               wr_data,
  input  logic [SLOT_W-1:0]               rd_slot,
  input  logic [BIDX_W-1:0]               rd_beat,
  output logic [NUM_SLOTS-1:0][BEATS-1:0] beat_mask,
  output logic [BEAT_W-1:0]               rd_beat_data
);
  localparam int ENTRIES = NUM_SLOTS * BEATS;

  logic [BEAT_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_slot, wr_beat}] <= wr_data;
  end

  assign rd_beat_data = mem[{rd_slot, rd_beat}];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        beat_mask[i] <= '0;
      end else if (alloc_fire && (alloc_slot == SLOT_W'(i))) begin
        beat_mask[i] <= '0;
      end else if (wr_en && (wr_slot == SLOT_W'(i))) begin
        beat_mask[i][wr_beat] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/srcb_read_port.sv
// Hit detection and the registered one-cycle read response.
module srcb_read_port #(
  parameter int NUM_SLOTS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int PIX_W     = 16,
  parameter int BEATS     = 8,
  parameter int BEAT_W    = 128,
  parameter int SLOT_W    = 2,
  parameter int BIDX_W    = 3,
  parameter int PIDX_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_valid,
  input  logic [ROW_W-1:0]                rd_row,
  input  logic [COL_W-1:0]                rd_col,
  input  logic [NUM_SLOTS-1:0]            slot_valid,
  input  logic [NUM_SLOTS-1:0][ROW_W-1:0] slot_tag,
  input  logic [NUM_SLOTS-1:0][BEATS-1:0] beat_mask,
  input  logic [BEAT_W-1:0]               beat_data,
  output logic [SLOT_W-1:0]               rd_slot,
  output logic [BIDX_W-1:0]               rd_beat,
  output logic [PIX_W-1:0]                rd_data,
  output logic                            rd_data_valid,
  output logic                            rd_miss
);
  import srcb_pkg::*;

  logic [PIDX_W-1:0] pix_idx;
  logic              hit;
  logic [PIX_W-1:0]  picked;
  rsp_kind_t         rsp_d;
  rsp_kind_t         rsp_q;

  always_comb begin
    rd_slot = rd_row[SLOT_W-1:0];
    rd_beat = rd_col[COL_W-1:PIDX_W];
    pix_idx = rd_col[PIDX_W-1:0];
    hit     = slot_valid[rd_slot] && (slot_tag[rd_slot] == rd_row) &&
              beat_mask[rd_slot][rd_beat];
    picked  = beat_data[pix_idx*PIX_W +: PIX_W];
    if (!rd_valid) rsp_d = RSP_IDLE;
    else if (hit)  rsp_d = RSP_HIT;
    else           rsp_d = RSP_MISS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q   <= RSP_IDLE;
      rd_data <= '0;
    end else begin
      rsp_q <= rsp_d;
      if (rsp_d == RSP_HIT) rd_data <= picked;
    end
  end

  assign rd_data_valid = (rsp_q == RSP_HIT);
  assign rd_miss       = (rsp_q == RSP_MISS);
endmodule

// File: rtl/sliding_row_cache.sv
module sliding_row_cache #(
  parameter int NUM_SLOTS = 4,
  parameter int ROW_PIX   = 64,
  parameter int PIX_W     = 16,
  parameter int BEAT_W    = 128,
  parameter int ROW_W     = 8,
  parameter int NUM_ROWS  = 64,
  localparam int PIX_PER_BEAT = BEAT_W / PIX_W,
  localparam int BEATS        = ROW_PIX / PIX_PER_BEAT,
  localparam int COL_W        = $clog2(ROW_PIX),
  localparam int BIDX_W       = $clog2(BEATS),
  localparam int PIDX_W       = $clog2(PIX_PER_BEAT),
  localparam int SLOT_W       = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ROW_W-1:0]  req_row,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ROW_W-1:0]  fill_row,
  input  logic [BIDX_W-1:0] fill_beat,
  input  logic [BEAT_W-1:0] fill_data,
  input  logic              row_done,
  input  logic              rd_valid,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [COL_W-1:0]  rd_col,
  output logic [PIX_W-1:0]  rd_data,
  output logic              rd_data_valid,
  output logic              rd_miss
);
  logic                            alloc_fire;
  logic [SLOT_W-1:0]               alloc_slot;
  logic [NUM_SLOTS-1:0]            slot_valid;
  logic [NUM_SLOTS-1:0][ROW_W-1:0] slot_tag;
  logic [NUM_SLOTS-1:0][BEATS-1:0] beat_mask;
  logic [BEAT_W-1:0]               beat_data;
  logic [SLOT_W-1:0]               fill_slot;
  logic                            wr_en;
  logic [SLOT_W-1:0]               rd_slot;
  logic [BIDX_W-1:0]               rd_beat;

  assign fill_ready = 1'b1;

  always_comb begin
    fill_slot = fill_row[SLOT_W-1:0];
    wr_en     = fill_valid && slot_valid[fill_slot] &&
                (slot_tag[fill_slot] == fill_row);
  end

  srcb_window_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .ROW_W(ROW_W), .NUM_ROWS(NUM_ROWS), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .row_done(row_done),
    .req_valid(req_valid), .req_row(req_row), .alloc_fire(alloc_fire),
    .alloc_slot(alloc_slot), .slot_valid(slot_valid), .slot_tag(slot_tag)
  );

  srcb_slot_store #(
    .NUM_SLOTS(NUM_SLOTS), .BEATS(BEATS), .BEAT_W(BEAT_W),
    .SLOT_W(SLOT_W), .BIDX_W(BIDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .alloc_slot(alloc_slot),
    .wr_en(wr_en), .wr_slot(fill_slot), .wr_beat(fill_beat), .wr_data(fill_data),
    .rd_slot(rd_slot), .rd_beat(rd_beat), .beat_mask(beat_mask),
    .rd_beat_data(beat_data)
  );

  srcb_read_port #(
    .NUM_SLOTS(NUM_SLOTS), .ROW_W(ROW_W), .COL_W(COL_W), .PIX_W(PIX_W),
    .BEATS(BEATS), .BEAT_W(BEAT_W), .SLOT_W(SLOT_W), .BIDX_W(BIDX_W),
    .PIDX_W(PIDX_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_row(rd_row),
    .rd_col(rd_col), .slot_valid(slot_valid), .slot_tag(slot_tag),
    .beat_mask(beat_mask), .beat_data(beat_data), .rd_slot(rd_slot),
    .rd_beat(rd_beat), .rd_data(rd_data), .rd_data_valid(rd_data_valid),
    .rd_miss(rd_miss)
  );
endmodule

// File: rtl/sliding_row_cache_chk.sv
module sliding_row_cache_chk #(
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [ROW_W-1:0] req_row,
  input logic             rd_valid,
  input logic             rd_data_valid,
  input logic             rd_miss
);
  // R5
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data_valid && rd_miss));

  // R4
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_valid || rd_miss) |-> $past(rd_valid));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row)));

  // R2
  req_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (req_row == $past(req_row) + 1'b1));
endmodule

bind sliding_row_cache sliding_row_cache_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_row(req_row), .rd_valid(rd_valid), .rd_data_valid(rd_data_valid),
  .rd_miss(rd_miss)
);

// File: tb/sliding_row_cache_bench.sv
`timescale 1ns/1ps
module sliding_row_cache_bench;
  localparam int NROWS = 64;
  localparam int SLOTS = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready;
  logic [7:0]   req_row;
  logic         fill_valid, fill_ready;
  logic [7:0]   fill_row;
  logic [2:0]   fill_beat;
  logic [127:0] fill_data;
  logic         row_done, rd_valid;
  logic [7:0]   rd_row;
  logic [5:0]   rd_col;
  logic [15:0]  rd_data;
  logic         rd_data_valid, rd_miss;

  always #2.5 clk = ~clk;

  sliding_row_cache u_sliding_row_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_row(fill_row), .fill_beat(fill_beat), .fill_data(fill_data),
    .row_done(row_done), .rd_valid(rd_valid), .rd_row(rd_row), .rd_col(rd_col),
    .rd_data(rd_data), .rd_data_valid(rd_data_valid), .rd_miss(rd_miss)
  );

  int checks = 0;
  int errors = 0;
  int m_base = 0;
  int m_next = 0;
  bit filled [0:NROWS+15][0:7];
  bit pend = 0;
  bit exp_hit = 0;
  logic [15:0] exp_data = '0;
  string pend_tag = "";

  function automatic logic [15:0] pix(int r, int c);
    return {8'(r) ^ 8'h5A, 8'(c)};
  endfunction

  function automatic logic [127:0] beat_of(int r, int b);
    logic [127:0] v;
    for (int k = 0; k < 8; k++) v[k*16 +: 16] = pix(r, b*8 + k);
    return v;
  endfunction

  function automatic bit m_req_valid();
    return ((m_next - m_base) < SLOTS) && (m_next < NROWS);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: check outputs of the previous edge, drive inputs, model the edge.
  task automatic step(bit rq, bit fv, int fr, int fb, bit rdone,
                      bit rv, int rr, int rc, string qtag, string dtag);
    bit mrv;
    mrv = m_req_valid();
    chk(req_valid == mrv, qtag, "req_valid", int'(req_valid), int'(mrv));
    if (mrv) chk(req_row == 8'(m_next), qtag, "req_row", int'(req_row), m_next);
    if (pend) begin
      chk(rd_data_valid == exp_hit, pend_tag, "rd_data_valid", int'(rd_data_valid), int'(exp_hit));
      chk(rd_miss == !exp_hit, pend_tag, "rd_miss", int'(rd_miss), int'(!exp_hit));
      if (exp_hit) chk(rd_data == exp_data, pend_tag, "rd_data", int'(rd_data), int'(exp_data));
    end else begin
      chk(!rd_data_valid && !rd_miss, "R5", "idle response",
          int'({rd_data_valid, rd_miss}), 0);
    end
    chk(fill_ready == 1'b1, "R3", "fill_ready", int'(fill_ready), 1);
    req_ready  = rq;
    fill_valid = fv;
    fill_row   = 8'(fr);
    fill_beat  = 3'(fb);
    fill_data  = beat_of(fr, fb);
    row_done   = rdone;
    rd_valid   = rv;
    rd_row     = 8'(rr);
    rd_col     = 6'(rc);
    pend     = rv;
    exp_hit  = rv && (rr >= m_base) && (rr < m_next) && filled[rr][rc/8];
    exp_data = pix(rr, rc);
    pend_tag = (dtag != "") ? dtag : (exp_hit ? "R4" : "R5");
    if (fv && (fr >= m_base) && (fr < m_next)) filled[fr][fb] = 1'b1;
    if (mrv && rq) m_next++;
    if (rdone && (m_next > m_base)) m_base++;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    rst_n = 1'b0; req_ready = 0; fill_valid = 0; fill_row = 0; fill_beat = 0;
    fill_data = '0; row_done = 0; rd_valid = 0; rd_row = 0; rd_col = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(req_valid == 1'b1, "R1", "req_valid", int'(req_valid), 1);
    chk(req_row == 8'd0, "R1", "req_row", int'(req_row), 0);
    chk(!rd_data_valid && !rd_miss, "R1", "response flags",
        int'({rd_data_valid, rd_miss}), 0);

    // R7 first read misses; R6 row_done with nothing resident is ignored
    step(0, 0, 0, 0, 1, 1, 0, 0, "R6", "R7");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R6", "");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2", "");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2", "");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2", "");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2", "");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2", "");   // window full: no request
    // R5 same-cycle fill and read of one beat misses
    step(1, 1, 0, 2, 0, 1, 0, 17, "R2", "R5");
    step(0, 1, 1, 7, 0, 1, 0, 17, "R2", "R4");
    step(0, 1, 4, 2, 0, 1, 0, 23, "R2", "R4");   // R3 fill of absent row 4
    step(0, 0, 0, 0, 0, 1, 1, 63, "R2", "R4");
    // R6 retire row 0: read in same cycle hits, later read misses
    step(0, 0, 0, 0, 1, 1, 0, 16, "R2", "R6");
    step(0, 0, 0, 0, 0, 1, 0, 17, "R6", "R6");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R6", "");
    // R8 reused slot shows nothing of row 0 nor of the dropped fill
    step(0, 0, 0, 0, 0, 1, 4, 17, "R2", "R8");
    step(0, 1, 4, 2, 0, 1, 4, 20, "R2", "R8");
    step(0, 0, 0, 0, 0, 1, 4, 20, "R2", "R4");

    // Random phase
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int fr, rr, lo;
      bit rdone;
      fr = m_base + int'($urandom % 5);
      lo = (m_base > 0) ? m_base - 1 : 0;
      rr = lo + int'($urandom % 6);
      rdone = ($urandom % 14) == 0;
      step(($urandom % 3) != 0, ($urandom % 2) == 0, fr, int'($urandom % 8),
           rdone, ($urandom % 4) != 0, rr, int'($urandom % 64), "R2", "");
      if (m_base >= NROWS) break;
    end
    // End of image: requests stop; retire with empty window ignored
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 1, 0, 0, 0, "R2", "");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2", "");
    chk(m_base == NROWS, "R6", "bench reached image end", m_base, NROWS);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule